// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block is the core of a four-channel direct memory access controller. Software programs each channel through a byte-wide register port: a 16-bit start address, a 16-bit transfer count, a mode byte and an 8-bit page byte. A channel with a pending, unmasked request makes the engine ask the host for the bus. Once the host grants it, the engine drives a 24-bit memory address, a one-hot acknowledge and the memory and I/O command strobes, one transfer per clock.

The sequencer has three states. `S_IDLE` holds the bus released and picks the highest-priority eligible channel (IDLE→WAIT). `S_WAIT` holds `hold_req` high until `hold_ack` is seen (WAIT→XFER). `S_XFER` performs one transfer per cycle. From `S_XFER` the engine stays in `S_XFER` (block mode, or demand mode while the request is held) or returns to `S_IDLE` (single mode, demand request dropped, or terminal count). Every 16-bit register is reached through a single shared byte-pointer flip-flop.

Top module: `dma4_core`

## Requirements
- R1: After reset or a write to the master-clear select (4'hD), all four mask bits are set, every address, count, page, mode, flag and request is zero, the byte pointer selects the low byte, and `hold_req`, `aen`, `dack` and `mem_addr` are zero.
- R2: Selects 4'h0–4'h7 reach the 16-bit registers: even select 2n is channel n's address and odd select 2n+1 is its count. Each access moves through the low byte and then the high byte, and both reads and writes toggle the shared pointer. A write to select 4'hC returns the pointer to the low byte. A write loads both the base and the current copy, and a read returns the current copy.
- R3: Channel 0 has the highest priority among channels whose request (`dreq` or software) is pending and unmasked. `hold_req` rises one cycle after the choice, and transfers begin in the cycle after `hold_ack` is seen high.
- R4: Mode bits 7:6 = 01 (single, and 11, which behaves the same) perform exactly one transfer per grant and then drop `hold_req`.
- R5: Mode bits 7:6 = 10 (block) transfer on every cycle without releasing the bus until terminal count.
- R6: Mode bits 7:6 = 00 (demand) keep transferring while the channel's request stays asserted. The engine releases the bus when the request drops and resumes where it stopped when the request returns.
- R7: `mem_addr` is {page, current address}. After each transfer the current address goes up by one, or down by one when mode bit 5 is set.
- R8: A count of N gives N+1 transfers. `tc` pulses during the last one, and that channel's flag appears in status bits 3:0 (select 4'h8). A status read clears the flags, but a flag set in the same cycle as the read survives.
- R9: At terminal count, a channel with mode bit 4 set reloads its current address and count from the base copies and stays unmasked. Any other channel gets its mask bit set.
- R10: Select 4'hA sets or clears one mask (bits 1:0 channel, bit 2 value). Select 4'hF loads all four masks from bits 3:0, and select 4'hE clears them all. A masked channel's request starts no transfer.
- R11: Select 4'h9 sets or clears a channel's software request (bits 1:0 channel, bit 2 value). The software request is serviced like `dreq` and is cleared at that channel's terminal count.
- R12: Mode bits 3:2 select the strobes during a transfer: 01 drives `mem_wr` and `io_rd`, 10 drives `mem_rd` and `io_wr`, and 00 or 11 drives none. Status bits 7:4 show the pending requests (`dreq` or software) of channels 3:0. Mode bits 1:0 pick which channel the mode byte is written to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational on `reg_sel` |
| page_wr | input | 1 | Writes `wdata` to the page byte of channel `reg_sel[1:0]` |
| dreq | input | 4 | Device transfer requests, active high |
| hold_req | output | 1 | Bus request to the host |
| hold_ack | input | 1 | Bus grant from the host |
| aen | output | 1 | High during every transfer cycle |
| dack | output | 4 | One-hot acknowledge of the active channel |
| mem_addr | output | 24 | Transfer memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal-count pulse |

## Verification
A status read can land in the same cycle as a channel's last transfer. The read clears the terminal-count flags while the transfer sets one. The bench provokes this with a block transfer of count 0: it waits for `aen` to rise and asserts the status read in that same cycle. The coincidence is judged correct when the following status read still returns the new channel's flag and the read after that returns zero.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH  = 4;
    localparam int CHW  = $clog2(NCH);
    localparam int AW   = 16;
    localparam int PW   = 8;
    localparam int SELW = 4;

    localparam logic [SELW-1:0] SEL_STATUS  = 4'h8;
    localparam logic [SELW-1:0] SEL_SWREQ   = 4'h9;
    localparam logic [SELW-1:0] SEL_MASK1   = 4'hA;
    localparam logic [SELW-1:0] SEL_MODE    = 4'hB;
    localparam logic [SELW-1:0] SEL_CLRPTR  = 4'hC;
    localparam logic [SELW-1:0] SEL_MCLR    = 4'hD;
    localparam logic [SELW-1:0] SEL_UNMASK  = 4'hE;
    localparam logic [SELW-1:0] SEL_MASKALL = 4'hF;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} seq_state_t;
    typedef enum logic [1:0] {M_DEMAND, M_SINGLE, M_BLOCK, M_CASCADE} xfer_mode_t;

    typedef struct packed {
        xfer_mode_t  mode;
        logic        dec;
        logic        autoi;
        logic [1:0]  kind;
    } chan_mode_t;
endpackage

// File: rtl/dma4_arb.sv
module dma4_arb
    import dma4_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           any_req,
    input  logic [CHW-1:0] pick,
    input  logic           hold_ack,
    input  xfer_mode_t     cur_mode,
    input  logic [1:0]     cur_kind,
    input  logic           last,
    input  logic           req_live,
    output logic [CHW-1:0] act_ch,
    output logic           hold_req,
    output logic           aen,
    output logic [NCH-1:0] dack,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr
);
    seq_state_t st;

    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            st     <= S_IDLE;
            act_ch <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (any_req) begin
                    act_ch <= pick;
                    st     <= S_WAIT;
                end
                S_WAIT: if (hold_ack) st <= S_XFER;
                S_XFER: begin
                    if (last) st <= S_IDLE;
                    else begin
                        unique case (cur_mode)
                            M_BLOCK:  st <= S_XFER;
                            M_DEMAND: st <= req_live ? S_XFER : S_IDLE;
                            default:  st <= S_IDLE;
                        endcase
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        hold_req = (st != S_IDLE);
        aen      = (st == S_XFER);
        dack     = aen ? (NCH'(1) << act_ch) : '0;
        mem_wr   = aen && (cur_kind == 2'b01);
        io_rd    = aen && (cur_kind == 2'b01);
        mem_rd   = aen && (cur_kind == 2'b10);
        io_wr    = aen && (cur_kind == 2'b10);
    end

    p_grant_starts_r3: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (st == S_WAIT && hold_ack) |=> aen);
    p_single_release_r4: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (aen && cur_mode == M_SINGLE) |=> !aen);
    p_block_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (aen && cur_mode == M_BLOCK && !last) |=> aen);
    p_tc_release_r8: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (aen && last) |=> !hold_req);
endmodule

// File: rtl/dma4_core.sv
module dma4_core
    import dma4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] reg_sel,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            page_wr,
    input  logic [NCH-1:0]  dreq,
    output logic            hold_req,
    input  logic            hold_ack,
    output logic            aen,
    output logic [NCH-1:0]  dack,
    output logic [PW+AW-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    output logic            tc
);
    logic [AW-1:0]  base_addr [NCH];
    logic [AW-1:0]  cur_addr  [NCH];
    logic [AW-1:0]  base_cnt  [NCH];
    logic [AW-1:0]  cur_cnt   [NCH];
    logic [PW-1:0]  page_q    [NCH];
    chan_mode_t     mode_q    [NCH];
    logic [NCH-1:0] mask_q, swreq_q, tcflag_q;
    logic           ptr_q;

    logic [CHW-1:0] act_ch, pick;
    logic [NCH-1:0] pending, eligible;
    logic           any_req, last, mclr, wide_sel, mask_wr;
    logic [CHW-1:0] sel_ch, cmd_ch;
    logic [AW-1:0]  rd_word;

    assign mclr     = reg_wr && (reg_sel == SEL_MCLR);
    assign wide_sel = !reg_sel[SELW-1];
    assign sel_ch   = reg_sel[CHW:1];
    assign cmd_ch   = wdata[CHW-1:0];
    assign mask_wr  = reg_wr && (reg_sel == SEL_MASK1 || reg_sel == SEL_UNMASK
                                 || reg_sel == SEL_MASKALL);
    assign pending  = dreq | swreq_q;
    assign eligible = pending & ~mask_q;
    assign last     = (cur_cnt[act_ch] == '0);
    assign tc       = aen && last;
    assign mem_addr = aen ? {page_q[act_ch], cur_addr[act_ch]} : '0;

    dma4_arb u_arb (.req(eligible), .any(any_req), .idx(pick));

    dma4_seq u_seq (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .any_req(any_req), .pick(pick),
        .hold_ack(hold_ack), .cur_mode(mode_q[act_ch].mode), .cur_kind(mode_q[act_ch].kind),
        .last(last), .req_live(eligible[act_ch]), .act_ch(act_ch), .hold_req(hold_req),
        .aen(aen), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
    );

    always_comb begin
        rd_word = reg_sel[0] ? cur_cnt[sel_ch] : cur_addr[sel_ch];
        if (wide_sel)                  rdata = ptr_q ? rd_word[AW-1:8] : rd_word[7:0];
        else if (reg_sel == SEL_STATUS) rdata = {pending, tcflag_q};
        else                           rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            for (int i = 0; i < NCH; i++) begin
                base_addr[i] <= '0;
                cur_addr[i]  <= '0;
                base_cnt[i]  <= '0;
                cur_cnt[i]   <= '0;
                page_q[i]    <= '0;
                mode_q[i]    <= '0;
            end
            mask_q   <= '1;
            swreq_q  <= '0;
            tcflag_q <= '0;
            ptr_q    <= 1'b0;
        end else begin
            // read side effects first, so a same-cycle terminal count wins
            if (reg_rd) begin
                if (reg_sel == SEL_STATUS) tcflag_q <= '0;
                if (wide_sel)              ptr_q    <= ~ptr_q;
            end
            if (aen) begin
                if (last) begin
                    tcflag_q[act_ch] <= 1'b1;
                    swreq_q[act_ch]  <= 1'b0;
                    if (mode_q[act_ch].autoi) begin
                        cur_addr[act_ch] <= base_addr[act_ch];
                        cur_cnt[act_ch]  <= base_cnt[act_ch];
                    end else begin
                        mask_q[act_ch] <= 1'b1;
                    end
                end else begin
                    cur_cnt[act_ch]  <= cur_cnt[act_ch] - 1'b1;
                    cur_addr[act_ch] <= mode_q[act_ch].dec ? cur_addr[act_ch] - 1'b1
                                                           : cur_addr[act_ch] + 1'b1;
                end
            end
            if (page_wr) page_q[reg_sel[CHW-1:0]] <= wdata;
            if (reg_wr) begin
                if (wide_sel) begin
                    ptr_q <= ~ptr_q;
                    if (reg_sel[0]) begin
                        if (ptr_q) begin
                            base_cnt[sel_ch][AW-1:8] <= wdata;
                            cur_cnt[sel_ch][AW-1:8]  <= wdata;
                        end else begin
                            base_cnt[sel_ch][7:0] <= wdata;
                            cur_cnt[sel_ch][7:0]  <= wdata;
                        end
                    end else begin
                        if (ptr_q) begin
                            base_addr[sel_ch][AW-1:8] <= wdata;
                            cur_addr[sel_ch][AW-1:8]  <= wdata;
                        end else begin
                            base_addr[sel_ch][7:0] <= wdata;
                            cur_addr[sel_ch][7:0]  <= wdata;
                        end
                    end
                end
                case (reg_sel)
                    SEL_SWREQ:   swreq_q[cmd_ch] <= wdata[2];
                    SEL_MASK1:   mask_q[cmd_ch]  <= wdata[2];
                    SEL_MODE:    mode_q[cmd_ch]  <= chan_mode_t'(wdata[7:2]);
                    SEL_CLRPTR:  ptr_q           <= 1'b0;
                    SEL_UNMASK:  mask_q          <= '0;
                    SEL_MASKALL: mask_q          <= wdata[NCH-1:0];
                    default: ;
                endcase
            end
        end
    end

    p_tc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        tc |=> tcflag_q[$past(act_ch)]);
    p_tc_mask_r9: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (tc && !mode_q[act_ch].autoi && !mask_wr) |=> mask_q[$past(act_ch)]);
    p_masked_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || mclr)
        (mask_q == '1 && !hold_req) |=> !hold_req);
endmodule

// File: tb/dma4_core_bench.sv
module dma4_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, page_wr = 1'b0, hold_ack = 1'b0;
    logic [7:0]  wdata = '0, rdata;
    logic [3:0]  dreq = '0, dack;
    logic        hold_req, aen, mem_rd, mem_wr, io_rd, io_wr, tc;
    logic [23:0] mem_addr;

    int n_run = 0, n_fail = 0;
    int n_xfer, n_tc, run_len, max_run;
    logic [23:0] first_addr, last_addr;
    logic [3:0]  first_dack;
    logic        saw_mrd, saw_mwr, saw_ird, saw_iwr;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma4_core u_dma4_core (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .wdata(wdata), .rdata(rdata), .page_wr(page_wr), .dreq(dreq), .hold_req(hold_req),
        .hold_ack(hold_ack), .aen(aen), .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc)
    );

    // host grants the bus one cycle after it is asked
    always @(posedge clk) hold_ack <= rst_n && hold_req;

    always @(negedge clk) begin
        if (aen) begin
            if (n_xfer == 0) begin first_addr = mem_addr; first_dack = dack; end
            n_xfer++; run_len++;
            if (run_len > max_run) max_run = run_len;
            last_addr = mem_addr;
            if (tc) n_tc++;
            saw_mrd |= mem_rd; saw_mwr |= mem_wr; saw_ird |= io_rd; saw_iwr |= io_wr;
        end else run_len = 0;
    end

    task automatic clr_mon();
        @(posedge clk);
        n_xfer = 0; n_tc = 0; run_len = 0; max_run = 0;
        first_addr = '0; last_addr = '0; first_dack = '0;
        saw_mrd = 0; saw_mwr = 0; saw_ird = 0; saw_iwr = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk); reg_sel = sel; wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_rd = 1'b1; #1 d = rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] sel, output logic [15:0] d);
        logic [7:0] lo, hi;
        wr(4'hC, 8'h00); rd(sel, lo); rd(sel, hi); d = {hi, lo};
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c,
                        input logic [1:0] md, input bit dec, input bit ai,
                        input logic [1:0] kind, input logic [7:0] pg);
        wr(4'hC, 8'h00);
        wr(4'(2*ch), a[7:0]); wr(4'(2*ch), a[15:8]);
        wr(4'(2*ch+1), c[7:0]); wr(4'(2*ch+1), c[15:8]);
        wr(4'hB, {md, dec, ai, kind, 2'(ch)});
        @(negedge clk); reg_sel = 4'(ch); wdata = pg; page_wr = 1'b1;
        @(negedge clk); page_wr = 1'b0;
    endtask

    // {read-and-check, select, data}: byte-pointer sequencing on channel 1
    localparam logic [12:0] VEC [15] = '{
        {1'b0, 4'hC, 8'h00}, {1'b0, 4'h2, 8'h34}, {1'b0, 4'h2, 8'h12},
        {1'b0, 4'hC, 8'h00}, {1'b1, 4'h2, 8'h34}, {1'b1, 4'h2, 8'h12},
        {1'b0, 4'h3, 8'h78}, {1'b0, 4'h3, 8'h56}, {1'b1, 4'h3, 8'h78},
        {1'b1, 4'h3, 8'h56}, {1'b0, 4'h3, 8'hAB}, {1'b0, 4'hC, 8'h00},
        {1'b1, 4'h3, 8'hAB}, {1'b1, 4'h3, 8'h56}, {1'b1, 4'h2, 8'h34}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_mon();

        // R1 reset state
        @(negedge clk);
        chk("R1 hold_req", hold_req, 0); chk("R1 aen", aen, 0);
        chk("R1 dack", dack, 0); chk("R1 mem_addr", mem_addr, 0);
        rd(4'h8, b); chk("R1 status", b, 8'h00);
        dreq = 4'b0001; repeat (6) @(negedge clk);
        chk("R1 masked after reset", hold_req, 0);
        rd(4'h8, b); chk("R12 pending bits", b, 8'h10);
        dreq = '0;

        // R2 byte pointer table
        foreach (VEC[i]) begin
            if (VEC[i][12]) begin
                rd(VEC[i][11:8], b); chk($sformatf("R2 vec %0d", i), b, VEC[i][7:0]);
            end else wr(VEC[i][11:8], VEC[i][7:0]);
        end

        // R5 R7 R12 block, increment, read-from-memory
        prog(1, 16'h1000, 16'd3, 2'b10, 0, 0, 2'b10, 8'h0A);
        wr(4'hA, 8'h01); clr_mon(); dreq[1] = 1'b1;
        repeat (20) @(negedge clk); dreq[1] = 1'b0;
        chk("R5 count", n_xfer, 4); chk("R5 one run", max_run, 4);
        chk("R7 first addr", first_addr, 24'h0A1000); chk("R7 last addr", last_addr, 24'h0A1003);
        chk("R8 tc pulses", n_tc, 1);
        chk("R12 read strobes", {saw_mrd, saw_iwr, saw_mwr, saw_ird}, 4'b1100);
        rd(4'h8, b); chk("R8 status flag", b, 8'h02);
        rd(4'h8, b); chk("R8 read clears", b, 8'h00);
        clr_mon(); dreq[1] = 1'b1; repeat (10) @(negedge clk); dreq[1] = 1'b0;
        chk("R9 masked at tc", n_xfer, 0);

        // R4 R12 single, write-to-memory
        prog(2, 16'h0200, 16'd2, 2'b01, 0, 0, 2'b01, 8'h00);
        wr(4'hA, 8'h02); clr_mon(); dreq[2] = 1'b1;
        repeat (30) @(negedge clk); dreq[2] = 1'b0;
        chk("R4 count", n_xfer, 3); chk("R4 one per grant", max_run, 1);
        chk("R12 write strobes", {saw_mrd, saw_iwr, saw_mwr, saw_ird}, 4'b0011);

        // R6 R7 demand, decrement, verify
        prog(3, 16'h0005, 16'd5, 2'b00, 1, 0, 2'b00, 8'h12);
        wr(4'hA, 8'h03); clr_mon(); dreq[3] = 1'b1; k = 0;
        while (k < 3) begin @(negedge clk); if (aen) k++; end
        dreq[3] = 1'b0; repeat (10) @(negedge clk);
        chk("R6 suspended count", n_xfer, 3); chk("R6 bus released", hold_req, 0);
        chk("R7 decrement", last_addr, 24'h120003); chk("R6 no tc yet", n_tc, 0);
        dreq[3] = 1'b1; repeat (15) @(negedge clk); dreq[3] = 1'b0;
        chk("R6 resumed count", n_xfer, 6); chk("R6 tc", n_tc, 1);
        chk("R7 final addr", last_addr, 24'h120000);
        chk("R12 verify no strobes", {saw_mrd, saw_iwr, saw_mwr, saw_ird}, 4'b0000);

        // R3 fixed priority
        prog(0, 16'h0300, 16'd0, 2'b10, 0, 0, 2'b00, 8'h00);
        prog(2, 16'h0400, 16'd0, 2'b10, 0, 0, 2'b00, 8'h00);
        wr(4'hE, 8'h00); clr_mon(); dreq = 4'b0101;
        repeat (20) @(negedge clk); dreq = '0;
        chk("R3 ch0 first", first_dack, 4'b0001); chk("R3 both served", n_xfer, 2);

        // R9 auto-initialize
        prog(0, 16'h0300, 16'd1, 2'b10, 0, 1, 2'b00, 8'h00);
        wr(4'hA, 8'h00); clr_mon(); dreq[0] = 1'b1;
        do @(negedge clk); while (!aen);
        dreq[0] = 1'b0; repeat (10) @(negedge clk);
        chk("R9 autoinit count", n_xfer, 2);
        rd16(4'h0, w); chk("R9 addr reload", w, 16'h0300);
        rd16(4'h1, w); chk("R9 count reload", w, 16'h0001);
        clr_mon(); dreq[0] = 1'b1;
        do @(negedge clk); while (!aen);
        dreq[0] = 1'b0; repeat (10) @(negedge clk);
        chk("R9 stays unmasked", n_xfer, 2);

        // R11 software request
        rd(4'h8, b);
        prog(1, 16'h0010, 16'd0, 2'b10, 0, 0, 2'b00, 8'h00);
        wr(4'hA, 8'h05); wr(4'h9, 8'h05);
        rd(4'h8, b); chk("R11 sw pending", b, 8'h20);
        clr_mon(); wr(4'hA, 8'h01); repeat (10) @(negedge clk);
        chk("R11 serviced", n_xfer, 1);
        rd(4'h8, b); chk("R11 cleared at tc", b, 8'h02);
        wr(4'h9, 8'h06); wr(4'h9, 8'h02);
        rd(4'h8, b); chk("R11 sw clear", b, 8'h00);

        // R8 status read in the terminal-count cycle
        prog(1, 16'h0020, 16'd0, 2'b10, 0, 0, 2'b00, 8'h00);
        wr(4'hA, 8'h01); dreq[1] = 1'b1;
        do @(negedge clk); while (!aen);
        reg_sel = 4'h8; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; dreq[1] = 1'b0;
        rd(4'h8, b); chk("R8 set beats clear", b, 8'h02);
        rd(4'h8, b); chk("R8 then cleared", b, 8'h00);

        // R10 mask commands
        prog(2, 16'h0500, 16'd0, 2'b10, 0, 0, 2'b00, 8'h00);
        wr(4'hE, 8'h00); wr(4'hF, 8'h0F); clr_mon(); dreq[2] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 all-mask blocks", n_xfer, 0);
        wr(4'hA, 8'h02); repeat (10) @(negedge clk); dreq[2] = 1'b0;
        chk("R10 single unmask", n_xfer, 1);

        // R1 master clear
        wr(4'hD, 8'h00);
        rd16(4'h2, w); chk("R1 mclr addr", w, 16'h0000);
        clr_mon(); dreq[1] = 1'b1; repeat (10) @(negedge clk);
        chk("R1 mclr masks", n_xfer, 0);
        rd(4'h8, b); chk("R1 mclr status", b, 8'h20);
        dreq = '0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule